// File: doc/BRIEF.md
# Unfolded Digit-Serial Adder

This block adds two unsigned operand streams several bits at a time. Each clock it takes one digit of `DIGIT_J` bits from each operand and returns the matching `DIGIT_J` sum bits in the same cycle. The hardware is a bit-serial adder replicated `DIGIT_J` times: a ripple of full-adder lanes passes the carry from lane to lane, and one carry register carries the top lane's carry into lane 0 of the next digit.

Words of `WORD_W` bits follow each other back to back with no gaps. The carry must not cross from one word into the next, so the carry entering the lane that holds bit 0 of a word is forced to zero. `WORD_W` does not have to be a multiple of `DIGIT_J`. When it is not, a word can begin in any lane, and the set of lanes to clear repeats only after `LCM(WORD_W, DIGIT_J)` bits. A counter modulo `LCM/DIGIT_J` steps through that pattern. The lane masks for each count are computed when the design is elaborated. A low `inValid` freezes both the counter and the carry.

Top module: `digit_serial_adder`

## Requirements
- R1: Every `WORD_W`-bit word read back from `sumOut` equals the sum of the two operand words modulo 2^WORD_W.
- R2: Within a digit, lane j holds the stream bit that follows the bit in lane j-1. Each word is sent least significant bit first, and the sum bits for a digit appear in the same cycle as the operand digit.
- R3: The carry entering the lane that holds bit 0 of a word is zero, so a word's sum never depends on the previous word.
- R4: When `WORD_W` is not a multiple of `DIGIT_J`, words start in lanes other than 0. Take `WORD_W`=4 and `DIGIT_J`=3: word starts fall on lane 0 at count 0, lane 1 at count 1 and lane 2 at count 2, and no word starts at count 3. The carry is cleared in exactly those lanes.
- R5: The carry out of a word's most significant bit is discarded. For example, all ones plus one gives a zero word.
- R6: A cycle with `inValid` low leaves the carry register and the schedule counter unchanged, so the streams resume as if the stalled cycle had not happened.
- R7: A reset with `rst_n` low clears the carry register and sets the schedule counter to 0. The first valid digit after reset holds bit 0 of a word in lane 0.
- R8: A carry out of the top lane enters lane 0 of the next valid digit when that lane does not start a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | The current digits are valid; advances carry and schedule |
| opA | input | DIGIT_J | Digit of operand A, lane 0 is the earliest bit |
| opB | input | DIGIT_J | Digit of operand B, lane 0 is the earliest bit |
| sumOut | output | DIGIT_J | Sum digit, combinational from the inputs and the carry |

## Verification
If the schedule counter is off, or the carry register holds a wrong value, the damage shows up in `sumOut` on the next valid digit. There it appears as a sum bit flipped in a lane that starts a word, or in lane 0. The bench therefore compares every valid digit with a reference model that works on whole words, which pins a fault to the exact cycle. It also reassembles the words and checks the word sums. Directed words force overflow, a carry that crosses a digit boundary, and a clear in the middle of a digit. Stalls and a reset in the middle of a stream show whether state was held or restarted correctly.

// File: rtl/dsadd_pkg.sv
package dsadd_pkg;
  localparam int MAX_LANES = 32;

  typedef struct packed {
    logic                 step;
    logic [MAX_LANES-1:0] clrMask;
  } dsStrobe_t;

  function automatic int gcdOf(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcmOf(input int a, input int b);
    return (a / gcdOf(a, b)) * b;
  endfunction
endpackage

// File: rtl/dsadd_ctrl.sv
module dsadd_ctrl
  import dsadd_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int DIGIT_J = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  output dsStrobe_t strobes
);
  localparam int SPAN   = lcmOf(WORD_W, DIGIT_J);
  localparam int PERIOD = SPAN / DIGIT_J;
  localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  function automatic logic [MAX_LANES-1:0] laneMask(input int k);
    logic [MAX_LANES-1:0] m;
    m = '0;
    for (int j = 0; j < DIGIT_J; j++) begin
      if (((k * DIGIT_J + j) % WORD_W) == 0) m[j] = 1'b1;
    end
    return m;
  endfunction

  logic [MAX_LANES-1:0] maskRom [PERIOD];
  logic [CW-1:0]        schedCnt;

  for (genvar k = 0; k < PERIOD; k++) begin : g_rom
    assign maskRom[k] = laneMask(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      schedCnt <= '0;
    end else if (inValid) begin
      if (schedCnt == CW'(PERIOD - 1)) schedCnt <= '0;
      else                             schedCnt <= schedCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.step    = inValid;
    strobes.clrMask = maskRom[schedCnt];
  end

  a_r6_stall_count: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(schedCnt));
  a_r3_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && schedCnt == CW'(PERIOD - 1)) |=> (schedCnt == '0));
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(schedCnt) < PERIOD);
  a_r7_origin_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (schedCnt == '0) |-> strobes.clrMask[0]);
endmodule

// File: rtl/dsadd_datapath.sv
module dsadd_datapath
  import dsadd_pkg::*;
#(
  parameter int DIGIT_J = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dsStrobe_t          strobes,
  input  logic [DIGIT_J-1:0] opA,
  input  logic [DIGIT_J-1:0] opB,
  output logic [DIGIT_J-1:0] sumOut
);
  logic               carryQ;
  logic [DIGIT_J:0]   chain;
  logic [DIGIT_J-1:0] laneCin;

  assign chain[0] = carryQ;

  for (genvar j = 0; j < DIGIT_J; j++) begin : g_lane
    assign laneCin[j]  = strobes.clrMask[j] ? 1'b0 : chain[j];
    assign sumOut[j]   = opA[j] ^ opB[j] ^ laneCin[j];
    assign chain[j+1]  = (opA[j] & opB[j]) | (laneCin[j] & (opA[j] ^ opB[j]));

    a_r3_cleared_lane: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.clrMask[j] |-> (sumOut[j] == (opA[j] ^ opB[j])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            carryQ <= 1'b0;
    else if (strobes.step) carryQ <= chain[DIGIT_J];
  end

  a_r6_stall_carry: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.step |=> $stable(carryQ));
  a_r7_reset_carry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (carryQ == 1'b0));
endmodule

// File: rtl/digit_serial_adder.sv
module digit_serial_adder
  import dsadd_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int DIGIT_J = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [DIGIT_J-1:0] opA,
  input  logic [DIGIT_J-1:0] opB,
  output logic [DIGIT_J-1:0] sumOut
);
  dsStrobe_t strobes;

  dsadd_ctrl #(.WORD_W(WORD_W), .DIGIT_J(DIGIT_J)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .strobes (strobes)
  );

  dsadd_datapath #(.DIGIT_J(DIGIT_J)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .sumOut  (sumOut)
  );
endmodule

// File: tb/digit_serial_adder_tb.sv
module digit_serial_adder_tb;
  localparam int J = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic [J-1:0] opA = '0;
  logic [J-1:0] opB = '0;
  logic [J-1:0] sumW12;
  logic [J-1:0] sumW4;

  always #4 clk = ~clk;

  digit_serial_adder #(.WORD_W(12), .DIGIT_J(J)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB), .sumOut(sumW12));
  digit_serial_adder #(.WORD_W(4), .DIGIT_J(J)) u_dut_w4 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB), .sumOut(sumW4));

  int nChecks = 0;
  int nFails  = 0;
  int wa [64];
  int wb [64];
  int got [64];

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fillWords(input int w, input int n);
    int msk;
    msk = (1 << w) - 1;
    for (int k = 0; k < n; k++) begin
      wa[k] = int'($urandom) & msk;
      wb[k] = int'($urandom) & msk;
    end
    wa[0] = msk; wb[0] = 1;   // overflow: R5
    wa[1] = 7;   wb[1] = 1;   // carry crosses a digit: R8
    wa[2] = 0;   wb[2] = 0;   // clean start after overflow: R3
  endtask

  task automatic pulseReset();
    @(negedge clk);
    inValid = 1'b0;
    rst_n   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic runStream(input int w, input int n, input bit stalls,
                           input int cut, input string firstTag);
    int    total;
    int    limit;
    int    msk;
    bit    wasStall;
    int    cyc;
    int    expDigit;
    int    actDigit;
    string tag;
    msk      = (1 << w) - 1;
    total    = (n * w) / J;
    limit    = (cut > 0) ? cut : total;
    wasStall = 1'b0;
    cyc      = 0;
    for (int k = 0; k < n; k++) got[k] = 0;
    while (cyc < limit) begin
      @(negedge clk);
      if (stalls && ($urandom % 4 == 0)) begin
        inValid  = 1'b0;
        opA      = J'($urandom);
        opB      = J'($urandom);
        wasStall = 1'b1;
      end else begin
        inValid  = 1'b1;
        expDigit = 0;
        for (int j = 0; j < J; j++) begin
          int g;
          int wd;
          int pos;
          g   = cyc * J + j;
          wd  = g / w;
          pos = g % w;
          opA[j] = wa[wd][pos];
          opB[j] = wb[wd][pos];
          expDigit |= (((((wa[wd] + wb[wd]) & msk) >> pos) & 1) << j);
        end
        #2;
        actDigit = (w == 12) ? int'(sumW12) : int'(sumW4);
        if (cyc == 0)      tag = firstTag;
        else if (wasStall) tag = "R6";
        else if (w != 12)  tag = "R4";
        else               tag = "R2";
        check(tag, actDigit, expDigit);
        for (int j = 0; j < J; j++) begin
          int g;
          g = cyc * J + j;
          got[g / w] |= (((actDigit >> j) & 1) << (g % w));
        end
        wasStall = 1'b0;
        cyc++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    if (cut == 0) begin
      for (int k = 0; k < n; k++) begin
        if (k == 0)      tag = "R5";
        else if (k == 1) tag = "R8";
        else if (k == 2) tag = "R3";
        else if (w == 12) tag = "R1";
        else             tag = "R4";
        check(tag, got[k], (wa[k] + wb[k]) & msk);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: zero operands give a zero digit, R7
    @(negedge clk);
    opA = '0; opB = '0;
    #2;
    check("R7", int'(sumW12), 0);
    check("R7", int'(sumW4), 0);

    fillWords(12, 30);
    runStream(12, 30, 1'b0, 0, "R7");
    fillWords(12, 30);
    runStream(12, 30, 1'b1, 0, "R6");

    pulseReset();
    fillWords(4, 30);
    runStream(4, 30, 1'b0, 0, "R7");
    fillWords(4, 30);
    runStream(4, 30, 1'b1, 0, "R6");

    // stop inside a word with a carry pending, then restart after reset: R7
    pulseReset();
    fillWords(12, 3);
    runStream(12, 3, 1'b0, 2, "R8");
    pulseReset();
    fillWords(12, 30);
    runStream(12, 30, 1'b0, 0, "R7");

    pulseReset();
    fillWords(4, 3);
    runStream(4, 3, 1'b0, 2, "R8");
    pulseReset();
    fillWords(4, 30);
    runStream(4, 30, 1'b1, 0, "R7");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule